// File: doc/BRIEF.md
# Eight-Bit Single-Cycle Processor Core

This block is a small 8-bit processor that completes one 16-bit instruction on every clock. Instructions are fetched from a byte-wide program store that the integrating design fixes through a parameter. Each fetch pulls two consecutive bytes. The first byte carries the operation code and the register fields. The second byte carries a branch target, a data address or an immediate value. The core holds four 8-bit working registers, a return-address register for one level of subroutine call, a pair of condition flags (zero and negative) and a 256-byte data store.

A byte-wide input port and a registered byte-wide output port connect the core to its surroundings. The program counter is brought out for observation. An asynchronous active-low reset is synchronised inside the core, so execution starts from address 0 two clocks after reset is released.

Top module: `cpu8_core`

## Requirements
- R1: While reset is active and once it is released, the program counter, the output port and all four working registers read as zero.
- R2: Any instruction that is not a jump, a taken conditional branch, a call or a return advances the program counter by exactly 2.
- R3: The byte at the program counter holds the operation code in bits [7:4], the register index ra in bits [3:2] and rb in bits [1:0]. The byte at program counter + 1 holds the address or immediate.
- R4: ADD (code 1) and SUB (code 2) write ra+rb and ra-rb into ra, both truncated to 8 bits.
- R5: NAND (code 3) writes the bitwise inverse of (ra AND rb) into ra.
- R6: SHL (code 4) and SHR (code 5) shift ra by exactly one bit position, left or right, and fill the vacated bit with 0.
- R7: OUT (code 6) loads ra into the output port register, which then holds that value until the next OUT. IN (code 7) writes the input port into ra.
- R8: MOV (code 8) copies rb into ra. LOADIMM (code 15) writes the second byte into ra.
- R9: BR (code 9) sets the program counter to the second byte.
- R10: Code 10 branches to the second byte when the selected flag is set, and otherwise falls through by 2. First-byte bit 3 = 0 selects the zero flag and bit 3 = 1 selects the negative flag.
- R11: Only ADD, SUB, NAND, SHL and SHR update the flags. Zero is set for a result of 0 and negative copies result bit 7. All other instructions leave both flags unchanged.
- R12: BR.SUB (code 11) saves program counter + 2 in the return register and jumps to the second byte. RETURN (code 12) loads the program counter from the return register.
- R13: STORE (code 14) writes ra into data memory at the second byte and changes no register. LOAD (code 13) writes the data-memory byte at the second byte into ra.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| in_port | input | 8 | Byte sampled by the IN instruction |
| out_port | output | 8 | Registered byte written by the OUT instruction |
| pc_dbg | output | 8 | Current program counter |

## Verification
The test program places an OUT on the fall-through path of every branch. A conditional branch that ignores its select bit, a flag that a LOADIMM of zero disturbs, or a jump that lands one word off therefore produces an extra or missing byte on the output port. The shift values are chosen with bit 7 and bit 0 set, so an arithmetic right shift or a rotate shows up as a wrong byte. The subroutine case changes a register inside the callee and outputs it after the return, which exposes a return register that saved the call address instead of the one after it. The LOAD path reads back a byte after the source register has been overwritten, so a store to the wrong address or a load that returns the register file value fails.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int INSTR_W   = 2 * DATA_W;
  localparam int NUM_REGS  = 4;
  localparam int RIDX_W    = $clog2(NUM_REGS);
  localparam int MEM_BYTES = 1 << ADDR_W;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_NAND = 4'd3,
    OP_SHL  = 4'd4,  OP_SHR  = 4'd5,  OP_OUT  = 4'd6,  OP_IN   = 4'd7,
    OP_MOV  = 4'd8,  OP_JMP  = 4'd9,  OP_BCND = 4'd10, OP_CALL = 4'd11,
    OP_RET  = 4'd12, OP_LD   = 4'd13, OP_ST   = 4'd14, OP_LDI  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_NAND, ALU_SHL, ALU_SHR, ALU_PASSB
  } alu_op_e;

  typedef enum logic [2:0] {
    PC_SEQ, PC_JMP, PC_COND, PC_CALL, PC_RET
  } pc_sel_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_PORT
  } wb_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    use_ea;
    alu_op_e alu_op;
    logic    flag_we;
    logic    mem_we;
    wb_sel_e wb_sel;
    pc_sel_e pc_sel;
    logic    out_we;
  } ctrl_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_PASSB;
    ctrl.wb_sel = WB_ALU;
    ctrl.pc_sel = PC_SEQ;
    unique case (op)
      OP_NOP:  ;
      OP_ADD:  begin ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; ctrl.alu_op = ALU_ADD;  end
      OP_SUB:  begin ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; ctrl.alu_op = ALU_SUB;  end
      OP_NAND: begin ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; ctrl.alu_op = ALU_NAND; end
      OP_SHL:  begin ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; ctrl.alu_op = ALU_SHL;  end
      OP_SHR:  begin ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; ctrl.alu_op = ALU_SHR;  end
      OP_OUT:  ctrl.out_we = 1'b1;
      OP_IN:   begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_PORT; end
      OP_MOV:  ctrl.reg_we = 1'b1;
      OP_JMP:  ctrl.pc_sel = PC_JMP;
      OP_BCND: ctrl.pc_sel = PC_COND;
      OP_CALL: ctrl.pc_sel = PC_CALL;
      OP_RET:  ctrl.pc_sel = PC_RET;
      OP_LD:   begin ctrl.reg_we = 1'b1; ctrl.use_ea = 1'b1; ctrl.wb_sel = WB_MEM; end
      OP_ST:   begin ctrl.mem_we = 1'b1; ctrl.use_ea = 1'b1; end
      OP_LDI:  begin ctrl.reg_we = 1'b1; ctrl.use_ea = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 4,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  logic [NREGS*DW-1:0] bank_flat;

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    logic          sel_en;
    logic [DW-1:0] val_d;
    logic [DW-1:0] val_q;

    always_comb begin
      sel_en = wr_en && (wr_idx == IW'(gi));
      val_d  = sel_en ? wr_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign bank_flat[gi*DW +: DW] = val_q;
  end

  assign rd_data_a = bank_flat[rd_idx_a*DW +: DW];
  assign rd_data_b = bank_flat[rd_idx_b*DW +: DW];

  // R4
  rf_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx_a) |=> (bank_flat[$past(wr_idx)*DW +: DW] == $past(wr_data)));

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero,
  output logic          neg
);

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_NAND: y = ~(a & b);
      ALU_SHL:  y = {a[DW-2:0], 1'b0};
      ALU_SHR:  y = {1'b0, a[DW-1:1]};
      default:  y = b;
    endcase
    zero = (y == '0);
    neg  = y[DW-1];
  end

endmodule

// File: rtl/cpu8_dmem.sv
module cpu8_dmem #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  assign rd_data = cells[addr];

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter logic [8*MEM_BYTES-1:0] PROGRAM = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_port,
  output logic [DATA_W-1:0] out_port,
  output logic [ADDR_W-1:0] pc_dbg
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  // fetch
  logic [ADDR_W-1:0]  pc_q, pc_d, pc_inc1, pc_inc2;
  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  ea;
  logic [RIDX_W-1:0]  ra, rb;
  opcode_e            op;

  assign pc_inc1 = pc_q + ADDR_W'(1);
  assign pc_inc2 = pc_q + ADDR_W'(2);
  assign instr   = {PROGRAM[{pc_inc1, 3'b000} +: 8], PROGRAM[{pc_q, 3'b000} +: 8]};
  assign op      = opcode_e'(instr[7:4]);
  assign ra      = instr[3:2];
  assign rb      = instr[1:0];
  assign ea      = instr[15:8];

  ctrl_t ctrl;
  cpu8_decode u_decode (.op(op), .ctrl(ctrl));

  // operands and execute
  logic [DATA_W-1:0] rdata_a, rdata_b, opnd_b, alu_y, mem_rd, wb_data;
  logic              alu_zero, alu_neg;

  assign opnd_b = ctrl.use_ea ? ea : rdata_b;

  cpu8_alu #(.DW(DATA_W)) u_alu (
    .op(ctrl.alu_op), .a(rdata_a), .b(opnd_b),
    .y(alu_y), .zero(alu_zero), .neg(alu_neg)
  );

  cpu8_dmem #(.DW(DATA_W), .AW(ADDR_W)) u_dmem (
    .clk(clk), .wr_en(ctrl.mem_we), .addr(alu_y),
    .wr_data(rdata_a), .rd_data(mem_rd)
  );

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_data = mem_rd;
      WB_PORT: wb_data = in_port;
      default: wb_data = alu_y;
    endcase
  end

  cpu8_regfile #(.DW(DATA_W), .NREGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_l),
    .wr_en(ctrl.reg_we), .wr_idx(ra), .wr_data(wb_data),
    .rd_idx_a(ra), .rd_idx_b(rb),
    .rd_data_a(rdata_a), .rd_data_b(rdata_b)
  );

  // flags, link, output port, program counter: next state
  logic              zf_q, nf_q, zf_d, nf_d, cond_hit;
  logic [ADDR_W-1:0] link_q, link_d;
  logic [DATA_W-1:0] out_q, out_d;

  always_comb begin
    zf_d     = ctrl.flag_we ? alu_zero : zf_q;
    nf_d     = ctrl.flag_we ? alu_neg  : nf_q;
    out_d    = ctrl.out_we  ? rdata_a  : out_q;
    link_d   = (ctrl.pc_sel == PC_CALL) ? pc_inc2 : link_q;
    cond_hit = instr[3] ? nf_q : zf_q;
    unique case (ctrl.pc_sel)
      PC_JMP, PC_CALL: pc_d = ea;
      PC_COND:         pc_d = cond_hit ? ea : pc_inc2;
      PC_RET:          pc_d = link_q;
      default:         pc_d = pc_inc2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      pc_q   <= '0;
      link_q <= '0;
      out_q  <= '0;
      zf_q   <= 1'b0;
      nf_q   <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      link_q <= link_d;
      out_q  <= out_d;
      zf_q   <= zf_d;
      nf_q   <= nf_d;
    end
  end

  assign out_port = out_q;
  assign pc_dbg   = pc_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (ctrl.pc_sel == PC_SEQ) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (op != OP_OUT) |=> $stable(out_port));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_l)
    !(op inside {OP_ADD, OP_SUB, OP_NAND, OP_SHL, OP_SHR}) |=> ($stable(zf_q) && $stable(nf_q)));

  // R12
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (op == OP_CALL) |=> (link_q == $past(pc_q) + ADDR_W'(2) && pc_q == $past(ea)));

  // R13
  store_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (op == OP_ST) |-> !ctrl.reg_we);

endmodule

// File: tb/cpu8_core_tb.sv
`timescale 1ns/1ps
module cpu8_core_tb;
  import cpu8_pkg::*;

  localparam int PW = 8 * MEM_BYTES;

  function automatic logic [PW-1:0] put(logic [PW-1:0] p, int k, logic [15:0] w);
    logic [PW-1:0] r = p;
    r[k*16 +: 16] = w;
    return r;
  endfunction

  function automatic logic [15:0] fa(opcode_e o, int a, int b);
    return {8'h00, 4'(o), 2'(a), 2'(b)};
  endfunction

  function automatic logic [15:0] fl(opcode_e o, int a, logic [7:0] v);
    return {v, 4'(o), 2'(a), 2'b00};
  endfunction

  function automatic logic [15:0] fb(opcode_e o, logic s, logic [7:0] t);
    return {t, 4'(o), s, 3'b000};
  endfunction

  function automatic logic [PW-1:0] build_prog();
    logic [PW-1:0] p = '0;
    p = put(p, 0,  fa(OP_OUT, 0, 0));
    p = put(p, 1,  fa(OP_OUT, 1, 0));
    p = put(p, 2,  fa(OP_OUT, 2, 0));
    p = put(p, 3,  fa(OP_OUT, 3, 0));
    p = put(p, 4,  fl(OP_LDI, 0, 8'h7F));
    p = put(p, 5,  fl(OP_LDI, 1, 8'h01));
    p = put(p, 6,  fa(OP_ADD, 0, 1));
    p = put(p, 7,  fa(OP_OUT, 0, 0));
    p = put(p, 8,  fl(OP_LDI, 2, 8'h00));
    p = put(p, 9,  fb(OP_BCND, 1'b1, 8'h16));
    p = put(p, 10, fa(OP_OUT, 2, 0));
    p = put(p, 11, fb(OP_BCND, 1'b0, 8'h1A));
    p = put(p, 12, fa(OP_OUT, 0, 0));
    p = put(p, 13, fa(OP_SUB, 0, 0));
    p = put(p, 14, fb(OP_BCND, 1'b0, 8'h20));
    p = put(p, 15, fa(OP_OUT, 1, 0));
    p = put(p, 16, fa(OP_OUT, 0, 0));
    p = put(p, 17, fl(OP_LDI, 2, 8'hF0));
    p = put(p, 18, fl(OP_LDI, 3, 8'h3C));
    p = put(p, 19, fa(OP_NAND, 2, 3));
    p = put(p, 20, fa(OP_OUT, 2, 0));
    p = put(p, 21, fa(OP_SHL, 2, 2));
    p = put(p, 22, fa(OP_OUT, 2, 0));
    p = put(p, 23, fa(OP_SHR, 2, 2));
    p = put(p, 24, fa(OP_OUT, 2, 0));
    p = put(p, 25, fa(OP_SUB, 1, 3));
    p = put(p, 26, fa(OP_OUT, 1, 0));
    p = put(p, 27, fa(OP_IN, 3, 0));
    p = put(p, 28, fa(OP_OUT, 3, 0));
    p = put(p, 29, fa(OP_MOV, 0, 3));
    p = put(p, 30, fa(OP_OUT, 0, 0));
    p = put(p, 31, fl(OP_ST, 3, 8'h40));
    p = put(p, 32, fl(OP_LDI, 3, 8'h11));
    p = put(p, 33, fl(OP_LD, 1, 8'h40));
    p = put(p, 34, fa(OP_OUT, 1, 0));
    p = put(p, 35, fa(OP_OUT, 3, 0));
    p = put(p, 36, fb(OP_CALL, 1'b0, 8'h5A));
    p = put(p, 37, fa(OP_OUT, 2, 0));
    p = put(p, 38, fb(OP_JMP, 1'b0, 8'h60));
    p = put(p, 39, fa(OP_OUT, 3, 0));
    p = put(p, 45, fl(OP_LDI, 2, 8'h5A));
    p = put(p, 46, fb(OP_RET, 1'b0, 8'h00));
    p = put(p, 48, fa(OP_OUT, 0, 0));
    p = put(p, 49, fb(OP_JMP, 1'b0, 8'h62));
    return p;
  endfunction

  localparam logic [PW-1:0] PROG = build_prog();

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_port;
  logic [7:0] out_port;
  logic [7:0] pc_dbg;

  always #2.5 clk = ~clk;

  cpu8_core #(.PROGRAM(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_port(in_port),
    .out_port(out_port), .pc_dbg(pc_dbg)
  );

  int checks = 0;
  int errors = 0;
  logic timed_out = 1'b0;

  logic [7:0] q_val [$];
  string      q_tag [$];

  task automatic push_exp(logic [7:0] v, string tag);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: an OUT at prev_pc has retired once the PC moves on
  logic       mon_en = 1'b0;
  logic [7:0] prev_pc;

  always @(negedge clk) begin
    if (mon_en) begin
      if (PROG[{prev_pc, 3'b000} + 4 +: 4] == 4'(OP_OUT) && pc_dbg != prev_pc) begin
        if (q_val.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R7 unexpected output actual=%02h expected=none", out_port);
        end else begin
          check(q_tag.pop_front(), out_port, q_val.pop_front());
        end
      end
      prev_pc = pc_dbg;
    end
  end

  // watchdog
  initial begin
    repeat (2000) @(posedge clk);
    timed_out = 1'b1;
  end

  initial begin
    in_port = 8'hA5;
    rst_n   = 1'b0;
    push_exp(8'h00, "R1 reset R0");
    push_exp(8'h00, "R1 reset R1");
    push_exp(8'h00, "R1 reset R2");
    push_exp(8'h00, "R1 reset R3");
    push_exp(8'h80, "R4 add 7F+01");
    push_exp(8'h80, "R10 R11 branch paths");
    push_exp(8'h00, "R10 zero branch taken");
    push_exp(8'hCF, "R5 nand");
    push_exp(8'h9E, "R6 shl");
    push_exp(8'h4F, "R6 shr");
    push_exp(8'hC5, "R4 sub wrap");
    push_exp(8'hA5, "R7 in port");
    push_exp(8'hA5, "R8 mov");
    push_exp(8'hA5, "R13 load after store");
    push_exp(8'h11, "R8 loadimm");
    push_exp(8'h5A, "R12 return after call");
    push_exp(8'hA5, "R9 jump target");

    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_dbg, 8'h00);
    check("R1 out in reset", out_port, 8'h00);
    prev_pc = 8'h00;
    mon_en  = 1'b1;
    rst_n   = 1'b1;

    while (pc_dbg != 8'h02 && !timed_out) @(negedge clk);
    @(negedge clk);
    check("R2 R3 pc step", pc_dbg, 8'h04);
    @(negedge clk);
    check("R2 pc step", pc_dbg, 8'h06);

    while (q_val.size() != 0 && !timed_out) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9 halt loop", pc_dbg, 8'h62);

    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0 pending", q_val.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule